// File: doc/BRIEF.md
# MSI Interrupt Vector Arbiter

This block sits between application logic and the transaction layer of a PCIe endpoint. Application logic raises interrupt events, one pulse per vector. The block latches each event into a per-vector pending bit and keeps a per-vector enable mask that software reads and writes. An arbiter picks one vector that is pending, enabled and inside the allocated range. The block then presents a message-signalled interrupt request that carries that vector number. The request stays up until the transaction layer acknowledges it. The acknowledge clears the pending bit, and the next vector is then served.

Two configuration-space controls gate new requests: the MSI enable and the bus master enable. Software may have asked for more vectors than the host granted. Only the granted count is used, and it arrives as a log2 code. Round-robin selection keeps one busy vector from starving the others. A build parameter swaps the per-vector enable mask for one global enable bit.

Top module: `msi_vec_arb`

## Requirements
- R1: After reset the pending bits, the enable mask and the request are all 0. A pulse on `evt_i[n]` sets pending bit n at the next clock edge. The bit stays set until it is cleared, and repeated events on a vector that is already pending merge into that one bit, so the vector is served once.
- R2: A register write with `reg_sel_i`=0 (status) clears every pending bit whose `reg_wdata_i` bit is 1 and leaves the bits written 0 unchanged. An event in the same cycle as a clear leaves the bit set.
- R3: A register write with `reg_sel_i`=1 (enable) loads the enable mask, and `en_o` shows the new mask after the next clock edge. With `GLOBAL_EN`=1, bit 0 of the write data sets or clears every enable bit at once.
- R4: A vector can be chosen only if its pending bit and its enable bit are both 1 and its number is below 2^`alloc_log2_i`. Codes of 5 and above mean all 32 vectors. Pending vectors outside this set stay pending and are never requested.
- R5: `req_o` rises only if `msi_en_i` and `bus_master_en_i` were both 1 in the cycle before it rises.
- R6: Once `req_o` is high, it stays high and `vec_o` stays constant until the cycle in which `ack_i` is sampled high.
- R7: An acknowledge may arrive in the first cycle the request is high. At that clock edge the pending bit of `vec_o` clears, and `req_o` is low for at least the following cycle.
- R8: An event on the acknowledged vector in the same cycle as its acknowledge leaves that pending bit set, so the vector is requested again.
- R9: Selection is round-robin. The search starts at the vector after the last one acknowledged, wraps past the top, and starts at vector 0 after reset.
- R10: `ack_i` while `req_o` is low has no effect on the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NVEC | Interrupt event pulses, one per vector |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Write target: 0 status (write 1 to clear), 1 enable |
| reg_wdata_i | input | NVEC | Register write data |
| sts_o | output | NVEC | Pending bits, for read back |
| en_o | output | NVEC | Enable mask, for read back |
| msi_en_i | input | 1 | MSI enable from configuration space |
| bus_master_en_i | input | 1 | Bus master enable from configuration space |
| alloc_log2_i | input | 3 | log2 of the number of allocated vectors |
| req_o | output | 1 | Interrupt message request |
| vec_o | output | log2(NVEC) | Vector number carried by the request |
| ack_i | input | 1 | Acknowledge from the transaction layer |

## Verification
Several rules are checked on every cycle: the request handshake (hold and stability until acknowledge, the forced low cycle after it), the clearing of the served bit, the enable gating at each rising request, and the fact that a newly raised vector was pending, enabled and inside the allocated range. Other behaviour shows only in the bench's scenarios. That covers the round-robin order across several grants and wrap-around, the merging of repeated events, the re-arm when an event meets its own acknowledge, write-one-to-clear against a simultaneous event, and the fact that masked or out-of-range vectors stay pending without ever being requested.

// File: rtl/msi_arb_pkg.sv
package msi_arb_pkg;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    // Number of usable vectors for a log2 allocation code, capped at nvec.
    function automatic int alloc_limit(input logic [2:0] lg, input int nvec);
        int lim;
        lim = 1 << lg;
        if (lim > nvec) lim = nvec;
        return lim;
    endfunction

endpackage

// File: rtl/msi_vec_regs.sv
module msi_vec_regs
    import msi_arb_pkg::*;
#(
    parameter int NVEC      = 32,
    parameter bit GLOBAL_EN = 1'b0,
    localparam int VW       = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NVEC-1:0] evt_i,
    input  logic            wr_i,
    input  logic            sel_i,
    input  logic [NVEC-1:0] wdata_i,
    input  logic            clr_vld_i,
    input  logic [VW-1:0]   clr_idx_i,
    output logic [NVEC-1:0] sts_o,
    output logic [NVEC-1:0] en_o
);

    typedef struct packed {
        logic [NVEC-1:0] sts;
        logic [NVEC-1:0] en;
    } regs_t;

    regs_t           regs_d, regs_q;
    logic [NVEC-1:0] en_wr;
    logic [NVEC-1:0] clr;

    generate
        if (GLOBAL_EN) begin : g_global_en
            assign en_wr = {NVEC{wdata_i[0]}};
        end else begin : g_vector_en
            assign en_wr = wdata_i;
        end
    endgenerate

    always_comb begin
        regs_d = regs_q;
        clr    = '0;
        if (wr_i && sel_i == SEL_STATUS) clr = wdata_i;
        if (clr_vld_i) clr[clr_idx_i] = 1'b1;
        // a fresh event always wins over any clear in the same cycle
        regs_d.sts = (regs_q.sts & ~clr) | evt_i;
        if (wr_i && sel_i == SEL_ENABLE) regs_d.en = en_wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign sts_o = regs_q.sts;
    assign en_o  = regs_q.en;

endmodule

// File: rtl/msi_rr_pick.sv
module msi_rr_pick #(
    parameter int NVEC = 32,
    localparam int VW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic [NVEC-1:0] elig_i,
    input  logic [VW-1:0]   last_i,
    output logic            vld_o,
    output logic [VW-1:0]   idx_o
);

    int          start;
    int          pos;
    logic [VW-1:0] p;

    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        pos   = 0;
        p     = '0;
        start = (int'(last_i) >= NVEC - 1) ? 0 : int'(last_i) + 1;
        for (int k = 0; k < NVEC; k++) begin
            pos = start + k;
            if (pos >= NVEC) pos = pos - NVEC;
            p = VW'(pos);
            if (!vld_o && elig_i[p]) begin
                vld_o = 1'b1;
                idx_o = p;
            end
        end
    end

endmodule

// File: rtl/msi_req_ctl.sv
module msi_req_ctl #(
    parameter int NVEC = 32,
    localparam int VW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate_i,
    input  logic          pick_vld_i,
    input  logic [VW-1:0] pick_idx_i,
    input  logic          ack_i,
    output logic          req_o,
    output logic [VW-1:0] vec_o,
    output logic [VW-1:0] last_o,
    output logic          clr_vld_o,
    output logic [VW-1:0] clr_idx_o
);

    typedef struct packed {
        logic          req;
        logic [VW-1:0] vec;
        logic [VW-1:0] last;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        clr_vld_o = 1'b0;
        if (ctl_q.req) begin
            if (ack_i) begin
                ctl_d.req  = 1'b0;
                ctl_d.last = ctl_q.vec;
                clr_vld_o  = 1'b1;
            end
        end else if (gate_i && pick_vld_i) begin
            ctl_d.req = 1'b1;
            ctl_d.vec = pick_idx_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.req  <= 1'b0;
            ctl_q.vec  <= '0;
            ctl_q.last <= VW'(NVEC - 1);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_o     = ctl_q.req;
    assign vec_o     = ctl_q.vec;
    assign last_o    = ctl_q.last;
    assign clr_idx_o = ctl_q.vec;

endmodule

// File: rtl/msi_vec_arb.sv
module msi_vec_arb
    import msi_arb_pkg::*;
#(
    parameter int NVEC      = 32,
    parameter bit GLOBAL_EN = 1'b0,
    localparam int VW       = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NVEC-1:0] evt_i,
    input  logic            reg_wr_i,
    input  logic            reg_sel_i,
    input  logic [NVEC-1:0] reg_wdata_i,
    output logic [NVEC-1:0] sts_o,
    output logic [NVEC-1:0] en_o,
    input  logic            msi_en_i,
    input  logic            bus_master_en_i,
    input  logic [2:0]      alloc_log2_i,
    output logic            req_o,
    output logic [VW-1:0]   vec_o,
    input  logic            ack_i
);

    logic [NVEC-1:0] alloc_mask;
    logic [NVEC-1:0] elig;
    logic            pick_vld;
    logic [VW-1:0]   pick_idx;
    logic [VW-1:0]   last;
    logic            clr_vld;
    logic [VW-1:0]   clr_idx;

    msi_vec_regs #(.NVEC(NVEC), .GLOBAL_EN(GLOBAL_EN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .wr_i      (reg_wr_i),
        .sel_i     (reg_sel_i),
        .wdata_i   (reg_wdata_i),
        .clr_vld_i (clr_vld),
        .clr_idx_i (clr_idx),
        .sts_o     (sts_o),
        .en_o      (en_o)
    );

    generate
        for (genvar i = 0; i < NVEC; i++) begin : g_mask
            assign alloc_mask[i] = (i < alloc_limit(alloc_log2_i, NVEC));
        end
    endgenerate

    assign elig = sts_o & en_o & alloc_mask;

    msi_rr_pick #(.NVEC(NVEC)) u_pick (
        .elig_i (elig),
        .last_i (last),
        .vld_o  (pick_vld),
        .idx_o  (pick_idx)
    );

    msi_req_ctl #(.NVEC(NVEC)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_i     (msi_en_i & bus_master_en_i),
        .pick_vld_i (pick_vld),
        .pick_idx_i (pick_idx),
        .ack_i      (ack_i),
        .req_o      (req_o),
        .vec_o      (vec_o),
        .last_o     (last),
        .clr_vld_o  (clr_vld),
        .clr_idx_o  (clr_idx)
    );

endmodule

// File: rtl/msi_vec_arb_chk.sv
module msi_vec_arb_chk
    import msi_arb_pkg::*;
#(
    parameter int NVEC = 32,
    localparam int VW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NVEC-1:0] evt_i,
    input logic            msi_en_i,
    input logic            bus_master_en_i,
    input logic [2:0]      alloc_log2_i,
    input logic            ack_i,
    input logic            req_o,
    input logic [VW-1:0]   vec_o,
    input logic [NVEC-1:0] sts_o,
    input logic [NVEC-1:0] en_o
);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(vec_o)));

    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i && !evt_i[vec_o]) |=> !sts_o[$past(vec_o)]);

    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(msi_en_i && bus_master_en_i));

    p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> (int'(vec_o) < alloc_limit($past(alloc_log2_i), NVEC)));

    p_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> ((($past(sts_o & en_o)) >> vec_o) & NVEC'(1)) != '0);

endmodule

bind msi_vec_arb msi_vec_arb_chk #(.NVEC(NVEC)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .evt_i           (evt_i),
    .msi_en_i        (msi_en_i),
    .bus_master_en_i (bus_master_en_i),
    .alloc_log2_i    (alloc_log2_i),
    .ack_i           (ack_i),
    .req_o           (req_o),
    .vec_o           (vec_o),
    .sts_o           (sts_o),
    .en_o            (en_o)
);

// File: tb/tb_msi_vec_arb.sv
`timescale 1ns/1ps
module tb_msi_vec_arb;

    localparam int NV = 32;

    typedef struct packed {
        logic [NV-1:0] evts;
        logic [NV-1:0] en;
        logic [2:0]    alloc;
    } row_t;

    localparam row_t ROWS [5] = '{
        '{evts: 32'h0000_00F0, en: 32'hFFFF_FFFF, alloc: 3'd5},
        '{evts: 32'hFFFF_FFFF, en: 32'h0000_000F, alloc: 3'd1},
        '{evts: 32'h8000_0001, en: 32'hFFFF_FFFF, alloc: 3'd7},
        '{evts: 32'h0000_0300, en: 32'hFFFF_FEFF, alloc: 3'd4},
        '{evts: 32'h0000_00FF, en: 32'hFFFF_FFFF, alloc: 3'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NV-1:0] evt = '0;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [NV-1:0] reg_wdata = '0;
    logic [NV-1:0] sts;
    logic [NV-1:0] en;
    logic          msi_en = 1'b0;
    logic          bme = 1'b0;
    logic [2:0]    alloc = 3'd5;
    logic          req;
    logic [4:0]    vec;
    logic          ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int m_last = NV - 1;

    always #2 clk = ~clk;

    msi_vec_arb #(.NVEC(NV)) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(reg_wr),
        .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .sts_o(sts), .en_o(en),
        .msi_en_i(msi_en), .bus_master_en_i(bme), .alloc_log2_i(alloc),
        .req_o(req), .vec_o(vec), .ack_i(ack)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic sel, input logic [NV-1:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [NV-1:0] e);
        evt = e;
        step();
        evt = '0;
    endtask

    task automatic wait_req(output bit got);
        got = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (req) begin
                got = 1'b1;
                return;
            end
            step();
        end
    endtask

    function automatic int model_next(input logic [NV-1:0] set);
        int start;
        start = (m_last >= NV - 1) ? 0 : m_last + 1;
        for (int k = 0; k < NV; k++) begin
            int pos;
            logic [4:0] p;
            pos = start + k;
            if (pos >= NV) pos = pos - NV;
            p = 5'(pos);
            if (set[p]) return pos;
        end
        return -1;
    endfunction

    function automatic logic [NV-1:0] range_mask(input logic [2:0] lg);
        int lim;
        lim = 1 << lg;
        if (lim >= NV) return '1;
        return (NV'(1) << lim) - NV'(1);
    endfunction

    // Serve one request with the earliest acknowledge and check order (R9) and clear (R7).
    task automatic serve_one(inout logic [NV-1:0] set);
        bit got;
        int exp;
        logic [4:0] e5;
        wait_req(got);
        chk(got, "R5 request expected", 32'(req), 32'd1);
        exp = model_next(set);
        e5 = 5'(exp);
        chk(vec == e5, "R9 round-robin order", 32'(vec), 32'(exp));
        ack = 1'b1;
        step();
        ack = 1'b0;
        chk(!req, "R7 request low after ack", 32'(req), 32'd0);
        chk(!sts[e5], "R7 pending bit cleared", 32'(sts[e5]), 32'd0);
        set[e5] = 1'b0;
        m_last = exp;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [NV-1:0] set;
        bit got;
        repeat (3) step();
        chk(req == 1'b0, "R1 reset request", 32'(req), 32'd0);
        chk(sts == '0, "R1 reset pending", sts, 32'd0);
        chk(en == '0, "R1 reset enable", en, 32'd0);
        rst_n = 1'b1;
        step();

        // R3: enable write visible after one edge
        wr_reg(1'b1, '1);
        chk(en == '1, "R3 enable write", en, 32'hFFFF_FFFF);

        // R1: merged events
        pulse(NV'(1) << 5);
        pulse(NV'(1) << 5);
        chk(sts == 32'h20, "R1 merged pending", sts, 32'h20);

        // R5: gating
        msi_en = 1'b1; bme = 1'b0;
        repeat (4) step();
        chk(!req, "R5 no request without bus master", 32'(req), 32'd0);
        msi_en = 1'b0; bme = 1'b1;
        repeat (4) step();
        chk(!req, "R5 no request without msi enable", 32'(req), 32'd0);

        pulse(NV'(1) << 3);
        msi_en = 1'b1;
        set = 32'h28;
        wait_req(got);
        chk(got && vec == 5'd3, "R9 first grant after reset", 32'(vec), 32'd3);

        // R6: hold while no ack
        for (int i = 0; i < 3; i++) begin
            step();
            chk(req && vec == 5'd3, "R6 request held", {27'd0, vec}, 32'd3);
        end

        // R8: event on the same cycle as its ack
        ack = 1'b1; evt = NV'(1) << 3;
        step();
        ack = 1'b0; evt = '0;
        chk(!req, "R7 low after min-latency ack", 32'(req), 32'd0);
        chk(sts[3] == 1'b1, "R8 re-armed pending", 32'(sts[3]), 32'd1);
        m_last = 3;

        serve_one(set);
        serve_one(set);
        repeat (4) step();
        chk(!req, "R1 merged events served once", 32'(req), 32'd0);

        // R10: stray ack
        msi_en = 1'b0;
        pulse(NV'(1) << 7);
        ack = 1'b1;
        step();
        ack = 1'b0;
        chk(sts == 32'h80, "R10 ack while idle ignored", sts, 32'h80);

        // R2: write-one-to-clear
        wr_reg(1'b0, '0);
        chk(sts == 32'h80, "R2 zero write keeps bits", sts, 32'h80);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h180; evt = 32'h100;
        step();
        reg_wr = 1'b0; reg_wdata = '0; evt = '0;
        chk(sts == 32'h100, "R2 clear vs event", sts, 32'h100);
        wr_reg(1'b0, '1);
        chk(sts == '0, "R2 clear all", sts, 32'd0);

        // Table-driven scenarios
        for (int r = 0; r < 5; r++) begin
            logic [NV-1:0] exp_set;
            msi_en = 1'b0; bme = 1'b1;
            alloc = ROWS[r].alloc;
            wr_reg(1'b1, ROWS[r].en);
            chk(en == ROWS[r].en, "R3 enable mask", en, ROWS[r].en);
            pulse(ROWS[r].evts);
            chk(sts == ROWS[r].evts, "R1 pending set", sts, ROWS[r].evts);
            exp_set = ROWS[r].evts & ROWS[r].en & range_mask(ROWS[r].alloc);
            msi_en = 1'b1;
            while (exp_set != '0) serve_one(exp_set);
            repeat (4) step();
            chk(!req, "R4 no request outside eligible set", 32'(req), 32'd0);
            exp_set = ROWS[r].evts & ~(ROWS[r].evts & ROWS[r].en & range_mask(ROWS[r].alloc));
            chk(sts == exp_set, "R4 masked vectors stay pending", sts, exp_set);
            msi_en = 1'b0;
            wr_reg(1'b0, '1);
            chk(sts == '0, "R2 cleanup clear", sts, 32'd0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule